// File: doc/BRIEF.md
# One-Time-Programmable Byte Store with Mode Decode

This block is a cycle-based, synthesizable model of a byte-wide memory that can be programmed once: a chip select, an output gate and a program strobe (all active low) choose between reading, programming, verifying and an identifier readout. Two digital flags replace the analog conditions: one says the programming supply is raised, the other says a high voltage is present on address bit 9. The tri-state data bus is modelled as a data output plus a drive-enable flag. When the drive-enable flag is low the bus counts as high impedance.

Programming can only clear bits. Each program write stores the old byte ANDed with the applied byte. The synchronous active-low reset stands for a full erase and sets every stored bit to 1. The address port is 17 bits wide. The number of stored words is a parameter, and address bits above the stored range are ignored, so higher addresses alias onto the same words. The identifier readout returns two fixed codes and takes priority over the array. Any combination of controls that is not a defined mode leaves the bus undriven.

Top module: `otp_byte_store`

## Requirements
- R1: While `rst_n` is low at a clock edge, every stored byte is set to 0xFF. After release, a read of any address returns 0xFF until it is programmed.
- R2: With `ceN` high, `driveEn` is 0 whatever `oeN`, `vppHigh` or `idVolt` are. Whenever `driveEn` is 0, `dataOut` is 0x00.
- R3: With `ceN`=0, `oeN`=0, `vppHigh`=0 and `idVolt`=0, `driveEn` is 1 and `dataOut` shows the stored byte at the address.
- R4: With `ceN`=0 and `oeN`=1, `driveEn` is 0.
- R5: With `vppHigh`=1, `ceN`=0 and `oeN`=1, a clock edge that sees `pgmN` low after seeing it high in the previous cycle replaces the addressed byte with (old AND `dataIn`).
- R6: Holding `pgmN` low produces only one write. Changing `dataIn` while the strobe stays low does not change the stored byte.
- R7: With `vppHigh`=1, `ceN`=0, `oeN`=0, `pgmN`=1 and `idVolt`=0, `driveEn` is 1 and the stored byte is driven.
- R8: With `ceN`=1 (program inhibit when `vppHigh`=1), a falling program strobe writes nothing.
- R9: With `idVolt`=1, `ceN`=0 and `oeN`=0, `driveEn` is 1 and `dataOut` is 0x89 if `addr[0]`=0 and 0x35 if `addr[0]`=1, regardless of the array contents.
- R10: In read mode (`vppHigh`=0), toggling `pgmN` writes nothing and does not change the output.
- R11: The undefined combination `ceN`=0, `oeN`=0, `vppHigh`=1, `pgmN`=0 leaves `driveEn` at 0 and writes nothing.
- R12: Only the low `STORE_AW` address bits (10 by default) select a word. Addresses that differ only above them reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low erase, sets all bits to 1 |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output gate, active low |
| pgmN | input | 1 | Program strobe, active low, edge-detected |
| vppHigh | input | 1 | Programming supply raised |
| idVolt | input | 1 | High voltage present on address bit 9 |
| addr | input | 17 | Byte address |
| dataIn | input | 8 | Byte to program |
| dataOut | output | 8 | Driven byte, 0 when not driving |
| driveEn | output | 1 | Bus driven; 0 stands for high impedance |

## Verification
A wrong edge-detect state would show up as either a missed or a repeated write. The bench detects this on the next verify cycle, one clock after the strobe vector, by comparing the driven byte with the expected AND of all applied bytes. A mode decode error shows up in the same cycle as a wrong `driveEn`, or as identifier codes appearing in place of array data. A corrupted erase shows up on the first read of any byte after reset, and an address alias error shows up on a read of the mirrored address.

// File: rtl/otp_pkg.sv
`timescale 1ns/1ps
package otp_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_DISABLE,
    MODE_READ,
    MODE_PROGRAM,
    MODE_VERIFY,
    MODE_IDENT,
    MODE_INVALID
  } otp_mode_e;

  typedef struct packed {
    logic writeEn;
    logic driveArray;
    logic driveId;
    logic idSel;
  } ctrl_strb_t;

  localparam logic [7:0] ID_MAKER_CODE  = 8'h89;
  localparam logic [7:0] ID_DEVICE_CODE = 8'h35;

endpackage

// File: rtl/otp_mode_ctrl.sv
`timescale 1ns/1ps
module otp_mode_ctrl
  import otp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       pgmN,
  input  logic       vppHigh,
  input  logic       idVolt,
  input  logic       addrLsb,
  output ctrl_strb_t strb
);

  logic      pgmPrev;
  otp_mode_e mode;

  // Strobe history for falling-edge detection; idles high.
  always_ff @(posedge clk) begin
    if (!rst_n) pgmPrev <= 1'b1;
    else        pgmPrev <= pgmN;
  end

  // Mode decode, identifier first among the driving modes.
  always_comb begin
    if (ceN)                          mode = MODE_STANDBY;
    else if (!oeN && idVolt)          mode = MODE_IDENT;
    else if (!oeN && !vppHigh)        mode = MODE_READ;
    else if (!oeN && vppHigh && pgmN) mode = MODE_VERIFY;
    else if (oeN && vppHigh)          mode = MODE_PROGRAM;
    else if (oeN)                     mode = MODE_DISABLE;
    else                              mode = MODE_INVALID;
  end

  always_comb begin
    strb.writeEn    = (mode == MODE_PROGRAM) && pgmPrev && !pgmN;
    strb.driveArray = (mode == MODE_READ) || (mode == MODE_VERIFY);
    strb.driveId    = (mode == MODE_IDENT);
    strb.idSel      = addrLsb;
  end

endmodule

// File: rtl/otp_array_dp.sv
`timescale 1ns/1ps
module otp_array_dp
  import otp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STORE_AW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrl_strb_t          strb,
  input  logic [STORE_AW-1:0] wordIdx,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic                driveEn
);

  localparam int DEPTH = 1 << STORE_AW;

  logic [DATA_W-1:0] cells [DEPTH];

  // Erase sets every bit; a write can only clear bits.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (strb.writeEn) begin
      cells[wordIdx] <= cells[wordIdx] & dataIn;
    end
  end

  always_comb begin
    if (strb.driveId)
      dataOut = strb.idSel ? DATA_W'(ID_DEVICE_CODE) : DATA_W'(ID_MAKER_CODE);
    else if (strb.driveArray)
      dataOut = cells[wordIdx];
    else
      dataOut = '0;
    driveEn = strb.driveId | strb.driveArray;
  end

endmodule

// File: rtl/otp_byte_store.sv
`timescale 1ns/1ps
module otp_byte_store
  import otp_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int STORE_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              pgmN,
  input  logic              vppHigh,
  input  logic              idVolt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn
);

  ctrl_strb_t ctrlStrb;

  generate
    if (STORE_AW < ADDR_W) begin : g_alias
      logic unusedAddrHi;
      assign unusedAddrHi = ^addr[ADDR_W-1:STORE_AW];
    end
  endgenerate

  otp_mode_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ceN     (ceN),
    .oeN     (oeN),
    .pgmN    (pgmN),
    .vppHigh (vppHigh),
    .idVolt  (idVolt),
    .addrLsb (addr[0]),
    .strb    (ctrlStrb)
  );

  otp_array_dp #(
    .DATA_W   (DATA_W),
    .STORE_AW (STORE_AW)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (ctrlStrb),
    .wordIdx (addr[STORE_AW-1:0]),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .driveEn (driveEn)
  );

endmodule

// File: rtl/otp_byte_store_chk.sv
`timescale 1ns/1ps
module otp_byte_store_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ceN,
  input logic              oeN,
  input logic              pgmN,
  input logic              vppHigh,
  input logic              idVolt,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dataOut,
  input logic              driveEn,
  input logic              wrStrobe
);

  // R2
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ceN |-> !driveEn);

  // R2
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !driveEn |-> (dataOut == '0));

  // R4
  gate_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceN && oeN) |-> !driveEn);

  // R9
  ident_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceN && !oeN && idVolt) |->
      (driveEn && dataOut == (addr[0] ? DATA_W'(8'h35) : DATA_W'(8'h89))));

  // R5
  write_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrStrobe |-> (vppHigh && !ceN && oeN && !pgmN && $past(pgmN)));

  // R6
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrStrobe |=> !wrStrobe);

  // R8
  inhibit_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ceN |-> !wrStrobe);

  // R10
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vppHigh |-> !wrStrobe);

  // R11
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceN && !oeN && vppHigh && !pgmN && !idVolt) |-> (!driveEn && !wrStrobe));

endmodule

bind otp_byte_store otp_byte_store_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ceN      (ceN),
  .oeN      (oeN),
  .pgmN     (pgmN),
  .vppHigh  (vppHigh),
  .idVolt   (idVolt),
  .addr     (addr),
  .dataOut  (dataOut),
  .driveEn  (driveEn),
  .wrStrobe (ctrlStrb.writeEn)
);

// File: tb/otp_byte_store_bench.sv
`timescale 1ns/1ps
module otp_byte_store_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ceN, oeN, pgmN, vppHigh, idVolt;
  logic [16:0] addr;
  logic [7:0]  dataIn;
  logic [7:0]  dataOut;
  logic        driveEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  otp_byte_store u_otp_byte_store (
    .clk(clk), .rst_n(rst_n), .ceN(ceN), .oeN(oeN), .pgmN(pgmN),
    .vppHigh(vppHigh), .idVolt(idVolt), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .driveEn(driveEn)
  );

  typedef struct packed {
    logic        ce, oe, pgm, vpp, idv;
    logic [16:0] a;
    logic [7:0]  d;
    logic        expDrv;
    logic [7:0]  expData;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,17'd5,    8'h00,1'b1,8'hFF,4'd1},  // R1 erased
    '{1'b1,1'b0,1'b1,1'b0,1'b0,17'd5,    8'h00,1'b0,8'h00,4'd2},  // R2 standby
    '{1'b0,1'b1,1'b1,1'b0,1'b0,17'd5,    8'h00,1'b0,8'h00,4'd4},  // R4 gate off
    '{1'b0,1'b1,1'b1,1'b1,1'b0,17'd5,    8'hA5,1'b0,8'h00,4'd5},  // R5 setup
    '{1'b0,1'b1,1'b0,1'b1,1'b0,17'd5,    8'hA5,1'b0,8'h00,4'd5},  // R5 strobe
    '{1'b0,1'b1,1'b0,1'b1,1'b0,17'd5,    8'h00,1'b0,8'h00,4'd6},  // R6 held low
    '{1'b0,1'b0,1'b1,1'b1,1'b0,17'd5,    8'h00,1'b1,8'hA5,4'd7},  // R7 verify
    '{1'b0,1'b1,1'b1,1'b1,1'b0,17'd5,    8'h3C,1'b0,8'h00,4'd5},  // R5 setup
    '{1'b0,1'b1,1'b0,1'b1,1'b0,17'd5,    8'h3C,1'b0,8'h00,4'd5},  // R5 strobe
    '{1'b0,1'b0,1'b1,1'b1,1'b0,17'd5,    8'h00,1'b1,8'h24,4'd5},  // R5 AND
    '{1'b1,1'b1,1'b1,1'b1,1'b0,17'd6,    8'h00,1'b0,8'h00,4'd8},  // R8 inhibit
    '{1'b1,1'b1,1'b0,1'b1,1'b0,17'd6,    8'h00,1'b0,8'h00,4'd8},  // R8 strobe
    '{1'b0,1'b0,1'b1,1'b0,1'b0,17'd6,    8'h00,1'b1,8'hFF,4'd8},  // R8 intact
    '{1'b0,1'b0,1'b0,1'b0,1'b0,17'd6,    8'h00,1'b1,8'hFF,4'd10}, // R10
    '{1'b0,1'b0,1'b1,1'b0,1'b0,17'd6,    8'h00,1'b1,8'hFF,4'd10}, // R10
    '{1'b0,1'b0,1'b0,1'b1,1'b0,17'd6,    8'h00,1'b0,8'h00,4'd11}, // R11
    '{1'b0,1'b0,1'b1,1'b1,1'b0,17'd6,    8'h00,1'b1,8'hFF,4'd11}, // R11 intact
    '{1'b0,1'b0,1'b1,1'b0,1'b1,17'd0,    8'h00,1'b1,8'h89,4'd9},  // R9 maker
    '{1'b0,1'b0,1'b1,1'b0,1'b1,17'd5,    8'h00,1'b1,8'h35,4'd9},  // R9 device
    '{1'b1,1'b0,1'b1,1'b0,1'b1,17'd5,    8'h00,1'b0,8'h00,4'd2},  // R2 ident off
    '{1'b0,1'b0,1'b1,1'b0,1'b0,17'h00405,8'h00,1'b1,8'h24,4'd12}, // R12 alias
    '{1'b0,1'b0,1'b1,1'b0,1'b0,17'd5,    8'h00,1'b1,8'h24,4'd3}   // R3 read
  };

  task automatic apply(input logic ce, oe, pgm, vpp, idv,
                       input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    ceN = ce; oeN = oe; pgmN = pgm; vppHigh = vpp; idVolt = idv;
    addr = a; dataIn = d;
  endtask

  task automatic check(input int req, input logic expDrv, input logic [7:0] expData);
    @(negedge clk);
    checks++;
    if (driveEn !== expDrv || dataOut !== expData) begin
      fails++;
      $display("FAIL R%0d: driveEn=%0b dataOut=%h expected driveEn=%0b dataOut=%h",
               req, driveEn, dataOut, expDrv, expData);
    end
  endtask

  initial begin
    rst_n = 1'b0; ceN = 1'b1; oeN = 1'b1; pgmN = 1'b1;
    vppHigh = 1'b0; idVolt = 1'b0; addr = '0; dataIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check(2, 1'b0, 8'h00);  // R2 reset state, deselected

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].ce, VECS[i].oe, VECS[i].pgm, VECS[i].vpp, VECS[i].idv,
            VECS[i].a, VECS[i].d);
      check(int'(VECS[i].req), VECS[i].expDrv, VECS[i].expData);
    end

    // R5 top word of the array
    apply(1'b0,1'b1,1'b1,1'b1,1'b0,17'h003FF,8'h00); check(5, 1'b0, 8'h00);
    apply(1'b0,1'b1,1'b0,1'b1,1'b0,17'h003FF,8'h00); check(5, 1'b0, 8'h00);
    apply(1'b0,1'b0,1'b1,1'b1,1'b0,17'h003FF,8'h00); check(5, 1'b1, 8'h00);
    // R3 neighbour untouched
    apply(1'b0,1'b0,1'b1,1'b0,1'b0,17'h003FE,8'h00); check(3, 1'b1, 8'hFF);

    // R1 erase restores all ones
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    apply(1'b0,1'b0,1'b1,1'b0,1'b0,17'd5,8'h00);     check(1, 1'b1, 8'hFF);
    apply(1'b0,1'b0,1'b1,1'b0,1'b0,17'h003FF,8'h00); check(1, 1'b1, 8'hFF);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule